// File: doc/BRIEF.md
# Sequential Byte Multiply/Divide Unit

This unit does one of two arithmetic operations on a pair of unsigned bytes. The operations are a multiply, which produces a 16-bit product, and a divide, which produces a quotient and a remainder. A controller presents the two operands and an operation select, then raises a start strobe for one clock. The unit captures the operands, works through them with an iterative engine, and returns the two result bytes. It also returns a carry flag and an overflow flag.

The latency never depends on the operand values. It is four machine cycles, and a machine cycle is a parameter counted in clocks (12 by default, so 48 clocks). Internally, a shift-and-add multiplier and a restoring divider each finish in eight steps. The results are then held until the fixed window closes, so the caller sees a completion time that does not vary. A start strobe that arrives while an operation is in flight is dropped.

Top module: `muldiv_seq`

## Requirements
- R1: A start strobe sampled while the unit is idle is accepted: `busy_o` is high from the next clock edge.
- R2: `done_o` is high for exactly one clock, beginning 4×CLKS_PER_MCYC clock edges after the edge that accepted the start. `busy_o` falls on that same edge, so `busy_o` and `done_o` are never high together.
- R3: A start strobe while `busy_o` is high is ignored: it does not move the completion time and does not change the operands or the operation in use.
- R4: With `op_div_i` = 0 (multiply), `a_o` gets bits 7:0 and `b_o` gets bits 15:8 of the unsigned product A×B.
- R5: After a multiply, `ov_o` is 1 exactly when the product is above 0xFF.
- R6: With `op_div_i` = 1 (divide) and B not zero, `a_o` gets the quotient of A/B, `b_o` gets the remainder, and `ov_o` is 0.
- R7: A divide with B = 0 returns `a_o` = A and `b_o` = B unchanged and sets `ov_o` to 1.
- R8: Every completed operation, multiply or divide, leaves `cy_o` at 0.
- R9: After reset, all outputs are 0. The result and flag outputs change only on the edge that raises `done_o`, and between completions they hold their values.
- R10: Operands and the operation select are captured at the accepting edge. Changes on `a_i`, `b_i` or `op_div_i` during the operation do not affect its result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-clock start strobe |
| op_div_i | input | 1 | Operation select: 0 multiply, 1 divide |
| a_i | input | 8 | First operand (multiplicand / dividend) |
| b_i | input | 8 | Second operand (multiplier / divisor) |
| a_o | output | 8 | Low product byte or quotient |
| b_o | output | 8 | High product byte or remainder |
| cy_o | output | 1 | Carry flag, cleared by every operation |
| ov_o | output | 1 | Overflow flag: wide product or zero divisor |
| busy_o | output | 1 | Operation in flight |
| done_o | output | 1 | One-clock completion pulse |

## Verification
The assertions assume two things about the inputs. First, reset is held for at least one edge before the first start. Second, the fixed window of 4×CLKS_PER_MCYC clocks is longer than the eight engine steps, so both engines have finished by the time `done_o` fires. The stimulus holds reset for several clocks and keeps the default machine-cycle length. It changes operands and raises extra start strobes only in the middle of an operation, which exercises the capture and ignore rules without breaking these assumptions.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

    localparam int unsigned MCYC_PER_OP = 4;

    typedef enum logic {
        OP_MUL = 1'b0,
        OP_DIV = 1'b1
    } mdu_op_e;

    typedef struct packed {
        logic cy;
        logic ov;
    } mdu_flags_t;

    function automatic int unsigned op_clocks(input int unsigned clks_per_mcyc);
        return MCYC_PER_OP * clks_per_mcyc;
    endfunction

endpackage

// File: rtl/mdu_timer.sv
module mdu_timer #(
    parameter int unsigned TOTAL = 48
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic accept_o,
    output logic fire_o,
    output logic busy_o,
    output logic done_o
);
    localparam int unsigned CNT_W = (TOTAL > 2) ? $clog2(TOTAL) : 1;

    logic [CNT_W-1:0] cnt;

    assign accept_o = start_i && !busy_o;
    assign fire_o   = busy_o && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            busy_o <= 1'b0;
            done_o <= 1'b0;
        end else begin
            done_o <= fire_o;
            if (accept_o) begin
                cnt    <= CNT_W'(TOTAL - 1);
                busy_o <= 1'b1;
            end else if (fire_o) begin
                busy_o <= 1'b0;
            end else if (busy_o) begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    p_accept_r1: assert property (@(posedge clk) disable iff (rst)
        accept_o |=> busy_o && (cnt == CNT_W'(TOTAL - 1)));

    p_one_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_count_on_r3: assert property (@(posedge clk) disable iff (rst)
        (busy_o && cnt != '0) |=> busy_o && (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/mdu_mul_engine.sv
module mdu_mul_engine #(
    parameter int unsigned W = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load_i,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    output logic [2*W-1:0] prod_o,
    output logic           fin_o
);
    localparam int unsigned STEP_W = $clog2(W + 1);

    logic [2*W-1:0]    prod;
    logic [W-1:0]      mcand;
    logic [STEP_W-1:0] step;
    logic [W:0]        sum;

    // add the multiplicand into the upper half when the current multiplier bit is set
    assign sum    = {1'b0, prod[2*W-1:W]} + {1'b0, (prod[0] ? mcand : {W{1'b0}})};
    assign fin_o  = (step == STEP_W'(W));
    assign prod_o = prod;

    always_ff @(posedge clk) begin
        if (rst) begin
            prod  <= '0;
            mcand <= '0;
            step  <= '0;
        end else if (load_i) begin
            prod  <= {{W{1'b0}}, b_i};
            mcand <= a_i;
            step  <= '0;
        end else if (!fin_o) begin
            prod <= {sum, prod[W-1:1]};
            step <= step + 1'b1;
        end
    end

    p_mul_fin_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (fin_o && !load_i) |=> fin_o && $stable(prod));

endmodule

// File: rtl/mdu_div_engine.sv
module mdu_div_engine #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] quo_o,
    output logic [W-1:0] rem_o,
    output logic         fin_o
);
    localparam int unsigned STEP_W = $clog2(W + 1);

    logic [2*W-1:0]    rq;
    logic [W-1:0]      dvs;
    logic [STEP_W-1:0] step;
    logic [W:0]        trial;
    logic [W:0]        diff;

    assign trial = rq[2*W-1:W-1];
    assign diff  = trial - {1'b0, dvs};
    assign fin_o = (step == STEP_W'(W));
    assign quo_o = rq[W-1:0];
    assign rem_o = rq[2*W-1:W];

    always_ff @(posedge clk) begin
        if (rst) begin
            rq   <= '0;
            dvs  <= '0;
            step <= '0;
        end else if (load_i) begin
            rq   <= {{W{1'b0}}, a_i};
            dvs  <= b_i;
            step <= '0;
        end else if (!fin_o) begin
            if (!diff[W]) rq <= {diff[W-1:0], rq[W-2:0], 1'b1};
            else          rq <= {rq[2*W-2:0], 1'b0};
            step <= step + 1'b1;
        end
    end

    p_div_rem_bound_r6: assert property (@(posedge clk) disable iff (rst)
        (fin_o && dvs != '0) |-> (rem_o < dvs));

endmodule

// File: rtl/muldiv_seq.sv
module muldiv_seq
    import mdu_pkg::*;
#(
    parameter int unsigned DATA_W        = 8,
    parameter int unsigned CLKS_PER_MCYC = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              op_div_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] a_o,
    output logic [DATA_W-1:0] b_o,
    output logic              cy_o,
    output logic              ov_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam int unsigned TOTAL = op_clocks(CLKS_PER_MCYC);

    logic                accept, fire;
    mdu_op_e             op_q;
    logic [DATA_W-1:0]   a_q, b_q;
    logic [2*DATA_W-1:0] prod;
    logic [DATA_W-1:0]   quo, rem;
    logic                mul_fin, div_fin;
    mdu_flags_t          flags;

    mdu_timer #(.TOTAL(TOTAL)) u_timer (
        .clk(clk), .rst(rst), .start_i(start_i),
        .accept_o(accept), .fire_o(fire), .busy_o(busy_o), .done_o(done_o)
    );

    mdu_mul_engine #(.W(DATA_W)) u_mul (
        .clk(clk), .rst(rst), .load_i(accept), .a_i(a_i), .b_i(b_i),
        .prod_o(prod), .fin_o(mul_fin)
    );

    mdu_div_engine #(.W(DATA_W)) u_div (
        .clk(clk), .rst(rst), .load_i(accept), .a_i(a_i), .b_i(b_i),
        .quo_o(quo), .rem_o(rem), .fin_o(div_fin)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q  <= OP_MUL;
            a_q   <= '0;
            b_q   <= '0;
            a_o   <= '0;
            b_o   <= '0;
            flags <= '0;
        end else begin
            if (accept) begin
                op_q <= mdu_op_e'(op_div_i);
                a_q  <= a_i;
                b_q  <= b_i;
            end
            if (fire) begin
                flags.cy <= 1'b0;
                if (op_q == OP_MUL) begin
                    a_o      <= prod[DATA_W-1:0];
                    b_o      <= prod[2*DATA_W-1:DATA_W];
                    flags.ov <= |prod[2*DATA_W-1:DATA_W];
                end else if (b_q == '0) begin
                    a_o      <= a_q;
                    b_o      <= b_q;
                    flags.ov <= 1'b1;
                end else begin
                    a_o      <= quo;
                    b_o      <= rem;
                    flags.ov <= 1'b0;
                end
            end
        end
    end

    assign cy_o = flags.cy;
    assign ov_o = flags.ov;

    p_excl_r2: assert property (@(posedge clk) disable iff (rst)
        !(busy_o && done_o));

    p_engines_ready_r2: assert property (@(posedge clk) disable iff (rst)
        fire |-> (mul_fin && div_fin));

    p_mul_ov_r5: assert property (@(posedge clk) disable iff (rst)
        (done_o && op_q == OP_MUL) |-> (ov_o == (b_o != '0)));

    p_div_ok_r6: assert property (@(posedge clk) disable iff (rst)
        (done_o && op_q == OP_DIV && b_q != '0) |-> (!ov_o && b_o < b_q));

    p_div_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (done_o && op_q == OP_DIV && b_q == '0) |-> (ov_o && a_o == a_q && b_o == b_q));

    p_carry_clear_r8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !cy_o);

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !fire |=> $stable(a_o) && $stable(b_o) && $stable(ov_o));

    p_capture_r10: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !fire) |=> $stable(a_q) && $stable(b_q) && $stable(op_q));

endmodule

// File: tb/test_muldiv_seq.sv
module test_muldiv_seq;
    localparam int CLK_PERIOD = 10;
    localparam int TOTAL      = 48;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic       op_div_i = 1'b0;
    logic [7:0] a_i = '0, b_i = '0;
    logic [7:0] a_o, b_o;
    logic       cy_o, ov_o, busy_o, done_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    muldiv_seq i_muldiv_seq (
        .clk(clk), .rst(rst), .start_i(start_i), .op_div_i(op_div_i),
        .a_i(a_i), .b_i(b_i), .a_o(a_o), .b_o(b_o), .cy_o(cy_o),
        .ov_o(ov_o), .busy_o(busy_o), .done_o(done_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_mul(input logic [7:0] a, input logic [7:0] b);
        return 16'(a) * 16'(b);
    endfunction

    function automatic logic [15:0] exp_div(input logic [7:0] a, input logic [7:0] b);
        if (b == 0) return {b, a};
        return {8'(a % b), 8'(a / b)};
    endfunction

    // run one operation; optionally scramble inputs and fire a stray start mid-flight
    task automatic run_op(input bit div, input logic [7:0] a, input logic [7:0] b, input bit stray);
        int k;
        logic [15:0] res;
        logic [7:0] ea, eb;
        bit eov;
        @(negedge clk);
        op_div_i = div; a_i = a; b_i = b; start_i = 1'b1;
        k = 0;
        do begin
            @(negedge clk);
            k++;
            if (k == 1) begin
                check(busy_o == 1'b1, "R1 busy after start", busy_o, 1);
                start_i  = 1'b0;
                a_i      = 8'($urandom);
                b_i      = 8'($urandom);
                op_div_i = ~div;
            end
            if (stray && k == 5)  start_i = 1'b1;
            if (stray && k == 6)  start_i = 1'b0;
            if (k == TOTAL) check(busy_o && !done_o, "R2 still busy before end", busy_o, 1);
        end while (!done_o && k < 400);
        check(k == TOTAL + 1, stray ? "R3 stray start kept timing" : "R2 latency", k, TOTAL + 1);
        check(busy_o == 1'b0, "R2 busy falls with done", busy_o, 0);
        if (div) begin
            res = exp_div(a, b);
            ea = res[7:0]; eb = res[15:8]; eov = (b == 0);
            if (b == 0) begin
                check(a_o == ea && b_o == eb, "R7 divide by zero keeps operands", {b_o, a_o}, {eb, ea});
                check(ov_o == 1'b1, "R7 divide by zero ov", ov_o, 1);
            end else begin
                check(a_o == ea && b_o == eb, stray ? "R10 R6 quotient/remainder" : "R6 quotient/remainder",
                      {b_o, a_o}, {eb, ea});
                check(ov_o == 1'b0, "R6 ov clear", ov_o, 0);
            end
        end else begin
            res = exp_mul(a, b);
            ea = res[7:0]; eb = res[15:8]; eov = (res > 16'hFF);
            check(a_o == ea && b_o == eb, stray ? "R10 R4 product" : "R4 product", {b_o, a_o}, {eb, ea});
            check(ov_o == eov, "R5 product overflow", ov_o, eov);
        end
        check(cy_o == 1'b0, "R8 carry cleared", cy_o, 0);
        @(negedge clk);
        check(done_o == 1'b0, "R2 done one clock", done_o, 0);
        check(a_o == ea && b_o == eb && ov_o == eov, "R9 outputs hold", {b_o, a_o}, {eb, ea});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(a_o == 0 && b_o == 0, "R9 reset results", {b_o, a_o}, 0);
        check(!busy_o && !done_o && !cy_o && !ov_o, "R9 reset flags",
              {busy_o, done_o, cy_o, ov_o}, 0);

        // directed corners
        run_op(1'b0, 8'h00, 8'h00, 1'b0);
        run_op(1'b0, 8'hFF, 8'hFF, 1'b0);
        run_op(1'b0, 8'h10, 8'h10, 1'b0);
        run_op(1'b0, 8'h0F, 8'h11, 1'b0);
        run_op(1'b1, 8'h00, 8'h00, 1'b0);
        run_op(1'b1, 8'hC8, 8'h00, 1'b0);
        run_op(1'b1, 8'hFF, 8'h01, 1'b0);
        run_op(1'b1, 8'h07, 8'h09, 1'b0);
        run_op(1'b1, 8'hFF, 8'hFF, 1'b0);
        run_op(1'b1, 8'h00, 8'h05, 1'b0);
        run_op(1'b0, 8'h9C, 8'h3B, 1'b1);
        run_op(1'b1, 8'hE1, 8'h0D, 1'b1);

        // constrained random: about one divide in eight has a zero divisor
        for (int i = 0; i < 200; i++) begin
            logic [7:0] ra, rb;
            bit rd;
            ra = 8'($urandom);
            rb = 8'($urandom);
            rd = 1'($urandom);
            if (rd && ($urandom % 8 == 0)) rb = 8'h00;
            run_op(rd, ra, rb, ($urandom % 4) == 0);
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule